// File: doc/BRIEF.md
# Bit-Destuffing Frame Receiver

This block sits behind a bit-recovery stage. It takes one line symbol per strobe and removes the filler ones that the transmitter adds to break up long runs of zeros. It then finds frame starts in the resulting bit stream and splits each frame into a header and a sequence of payload words. Stuffing is removed all the time, during idle gaps between frames as well as inside them. Seven zeros in a row cannot occur in legal traffic, so the block flags that as a line coding error and abandons any frame in progress.

A frame opens with three consecutive ones. A 16-bit header follows, and its last ten bits give the number of 16-bit payload words. The header fields come out with a single-cycle strobe. Each payload word has its own strobe, and the final word of the frame also carries an end marker. After the final word, or straight after the header when the length is zero, the block goes back to looking for the next frame start. The line strobe may be low for any number of cycles; those cycles change nothing.

Top module: `destuff_frame_rx`

## Requirements
- R1: After six consecutive zero symbols, the next one symbol is a filler: it is removed and does not reach the frame logic. Every one symbol, real or filler, clears the zero-run count.
- R2: A seventh consecutive zero symbol pulses `coding_err` for one cycle and clears the zero-run count. Any partial frame is dropped without output, and the block goes back to searching for a frame start.
- R3: While searching, a frame starts only after three consecutive destuffed ones. Zeros, and runs of one or two ones ended by a zero, produce no output.
- R4: The 16 destuffed bits after the start pattern form the header, MSB first: bits 15..12 are `hdr_type`, bits 11..10 are ignored, and bits 9..0 are `hdr_len`. `hdr_valid` pulses for one cycle with both fields.
- R5: Each group of 16 destuffed bits after the header is one payload word, MSB first. It appears on `word_data` with a one-cycle `word_valid` pulse. Exactly `hdr_len` words follow a header.
- R6: `word_valid` and `word_last` are both high on word number `hdr_len`, and only on that word. The block then goes back to searching. Ones inside a payload never restart a frame.
- R7: When `hdr_len` is 0, no words follow, and the symbols right after the header are searched for a new start.
- R8: Each header, word and error pulse is visible two clock cycles after the edge that accepted the line symbol completing it. Cycles with `line_valid` low change no state.
- R9: While `rst` is high, and in the first cycle after it, all strobes are low. Reset clears the zero-run count and drops any partial frame.
- R10: Filler removal applies in idle gaps and inside the header. A header of type 0, pad 0 and length 1023 carries one filler and is read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Recovered line symbol |
| line_valid | input | 1 | `line_bit` holds a new symbol this cycle |
| hdr_valid | output | 1 | One-cycle strobe: header fields are valid |
| hdr_type | output | 4 | Header type field |
| hdr_len | output | 10 | Payload length in words |
| word_valid | output | 1 | One-cycle strobe: `word_data` holds a payload word |
| word_data | output | 16 | Payload word |
| word_last | output | 1 | Marks the final word of the frame |
| coding_err | output | 1 | One-cycle strobe: seven zeros in a row were seen |

## Verification
Each header, word and error result takes two register stages: the filler remover, then the field parser. It is therefore due two cycles after the clock edge that accepted the symbol completing it. Filler symbols and idle strobe gaps add no latency to a result whose data symbol came before them. The bench notes the cycle in which it drives each completing data symbol and queues the expected value with a due cycle two later. Every output strobe, sampled on the falling edge, is then compared against the head of the queue for both value and cycle. For stimulus that must produce nothing, the bench checks that no strobe appeared within a settling window.

// File: rtl/destuff_rx_pkg.sv
package destuff_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HEAD = 2'd1,
    ST_BODY = 2'd2
  } rx_state_t;
endpackage

// File: rtl/zero_run_remover.sv
module zero_run_remover #(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic out_bit,
  output logic out_valid,
  output logic out_err
);
  localparam int CW = $clog2(RUN_LIMIT + 1);

  logic [CW-1:0] run_q;
  logic          at_limit;

  assign at_limit = (run_q == CW'(RUN_LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (in_valid) begin
        if (in_bit) begin
          // a one after a full zero run is filler and is dropped
          run_q     <= '0;
          out_bit   <= 1'b1;
          out_valid <= !at_limit;
        end else if (at_limit) begin
          run_q   <= '0;
          out_err <= 1'b1;
        end else begin
          run_q     <= run_q + CW'(1);
          out_bit   <= 1'b0;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_field_parser.sv
module frame_field_parser
  import destuff_rx_pkg::*;
#(
  parameter int SYNC_ONES = 3,
  parameter int TYPE_W    = 4,
  parameter int PAD_W     = 2,
  parameter int LEN_W     = 10,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_bit,
  input  logic              d_valid,
  input  logic              d_err,
  output logic              hdr_valid,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_last,
  output logic              coding_err
);
  localparam int HDR_W = TYPE_W + PAD_W + LEN_W;
  localparam int SH_W  = (HDR_W > WORD_W) ? HDR_W : WORD_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int ONE_W = $clog2(SYNC_ONES + 1);

  rx_state_t        st_q;
  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  sh_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [ONE_W-1:0] ones_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] len_nxt;

  assign sh_nxt  = {sh_q[SH_W-2:0], d_bit};
  assign len_nxt = sh_nxt[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      sh_q       <= '0;
      cnt_q      <= '0;
      ones_q     <= '0;
      left_q     <= '0;
      hdr_valid  <= 1'b0;
      hdr_type   <= '0;
      hdr_len    <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_last  <= 1'b0;
      coding_err <= 1'b0;
    end else begin
      hdr_valid  <= 1'b0;
      word_valid <= 1'b0;
      word_last  <= 1'b0;
      coding_err <= 1'b0;
      if (d_err) begin
        st_q       <= ST_HUNT;
        cnt_q      <= '0;
        ones_q     <= '0;
        coding_err <= 1'b1;
      end else if (d_valid) begin
        sh_q <= sh_nxt;
        case (st_q)
          ST_HUNT: begin
            if (!d_bit) begin
              ones_q <= '0;
            end else if (ones_q == ONE_W'(SYNC_ONES - 1)) begin
              ones_q <= '0;
              cnt_q  <= '0;
              st_q   <= ST_HEAD;
            end else begin
              ones_q <= ones_q + ONE_W'(1);
            end
          end
          ST_HEAD: begin
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              hdr_valid <= 1'b1;
              hdr_type  <= sh_nxt[HDR_W-1 -: TYPE_W];
              hdr_len   <= len_nxt;
              left_q    <= len_nxt;
              cnt_q     <= '0;
              st_q      <= (len_nxt == '0) ? ST_HUNT : ST_BODY;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          ST_BODY: begin
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
              word_valid <= 1'b1;
              word_data  <= sh_nxt[WORD_W-1:0];
              word_last  <= (left_q == LEN_W'(1));
              left_q     <= left_q - LEN_W'(1);
              cnt_q      <= '0;
              if (left_q == LEN_W'(1)) st_q <= ST_HUNT;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/destuff_frame_rx.sv
module destuff_frame_rx #(
  parameter int RUN_LIMIT = 6,
  parameter int SYNC_ONES = 3,
  parameter int TYPE_W    = 4,
  parameter int PAD_W     = 2,
  parameter int LEN_W     = 10,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_bit,
  input  logic              line_valid,
  output logic              hdr_valid,
  output logic [TYPE_W-1:0] hdr_type,
  output logic [LEN_W-1:0]  hdr_len,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_last,
  output logic              coding_err
);
  logic clean_bit;
  logic clean_valid;
  logic clean_err;

  zero_run_remover #(
    .RUN_LIMIT(RUN_LIMIT)
  ) u_remover (
    .clk      (clk),
    .rst      (rst),
    .in_bit   (line_bit),
    .in_valid (line_valid),
    .out_bit  (clean_bit),
    .out_valid(clean_valid),
    .out_err  (clean_err)
  );

  frame_field_parser #(
    .SYNC_ONES(SYNC_ONES),
    .TYPE_W   (TYPE_W),
    .PAD_W    (PAD_W),
    .LEN_W    (LEN_W),
    .WORD_W   (WORD_W)
  ) u_parser (
    .clk       (clk),
    .rst       (rst),
    .d_bit     (clean_bit),
    .d_valid   (clean_valid),
    .d_err     (clean_err),
    .hdr_valid (hdr_valid),
    .hdr_type  (hdr_type),
    .hdr_len   (hdr_len),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_last (word_last),
    .coding_err(coding_err)
  );
endmodule

// File: rtl/destuff_frame_rx_checker.sv
module destuff_frame_rx_checker #(
  parameter int TYPE_W = 4,
  parameter int LEN_W  = 10,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              line_bit,
  input logic              line_valid,
  input logic              hdr_valid,
  input logic [TYPE_W-1:0] hdr_type,
  input logic [LEN_W-1:0]  hdr_len,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              word_last,
  input logic              coding_err
);
  // words still owed by the current frame, as seen at the ports
  logic [LEN_W:0] owed_q;

  always_ff @(posedge clk) begin
    if (rst || coding_err) owed_q <= '0;
    else if (hdr_valid)    owed_q <= {1'b0, hdr_len};
    else if (word_valid && owed_q != '0) owed_q <= owed_q - 1'b1;
  end

  assert_hdr_single_R4: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> !hdr_valid);

  assert_word_single_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_word_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> owed_q != '0);

  assert_last_position_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_last == (owed_q == 1)));

  assert_last_with_word_R6: assert property (@(posedge clk) disable iff (rst)
    word_last |-> word_valid);

  assert_err_alone_R2: assert property (@(posedge clk) disable iff (rst)
    coding_err |-> !word_valid && !hdr_valid);

  assert_result_needs_symbol_R8: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || word_valid || coding_err) |-> $past(line_valid, 2));

  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hdr_valid && !word_valid && !coding_err);
endmodule

bind destuff_frame_rx destuff_frame_rx_checker #(
  .TYPE_W(TYPE_W),
  .LEN_W (LEN_W),
  .WORD_W(WORD_W)
) i_checker (
  .clk       (clk),
  .rst       (rst),
  .line_bit  (line_bit),
  .line_valid(line_valid),
  .hdr_valid (hdr_valid),
  .hdr_type  (hdr_type),
  .hdr_len   (hdr_len),
  .word_valid(word_valid),
  .word_data (word_data),
  .word_last (word_last),
  .coding_err(coding_err)
);

// File: tb/test_destuff_frame_rx.sv
`timescale 1ns/1ps
module test_destuff_frame_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_bit = 1'b0;
  logic        line_valid = 1'b0;
  logic        hdr_valid;
  logic [3:0]  hdr_type;
  logic [9:0]  hdr_len;
  logic        word_valid;
  logic [15:0] word_data;
  logic        word_last;
  logic        coding_err;

  int cyc = 0, n_chk = 0, n_bad = 0, zr = 0, drv_cyc = 0, dat_cyc = 0, ev_cnt = 0;
  bit gapmode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [31:0] exp_q[$];
  int due_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  destuff_frame_rx i_destuff_frame_rx (
    .clk(clk), .rst(rst), .line_bit(line_bit), .line_valid(line_valid),
    .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_len(hdr_len),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
    .coding_err(coding_err)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe(input logic [31:0] g);
    string tag;
    logic [31:0] e;
    int d;
    ev_cnt++;
    tag = (g[31:30] == 2'd1) ? "R4 R10 header" : (g[31:30] == 2'd2) ? "R1 R5 R6 word" : "R2 coding error";
    if (exp_q.size() == 0) check({tag, " unexpected"}, 1'b0, g, 32'h0);
    else begin
      e = exp_q.pop_front();
      d = due_q.pop_front();
      check(tag, g == e, g, e);
      check("R8 latency", cyc == d, cyc, d);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_valid)  observe({2'd1, 1'b0, 13'd0, hdr_type, 2'b00, hdr_len});
      if (word_valid) observe({2'd2, word_last, 13'd0, word_data});
      if (coding_err) observe({2'd3, 30'd0});
    end
  end

  // one raw line symbol, optionally preceded by an idle cycle with junk data
  task automatic line(input logic b);
    if (gapmode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[0]) begin
        @(negedge clk);
        line_valid = 1'b0;
        line_bit = ~b;
      end
    end
    @(negedge clk);
    line_bit = b;
    line_valid = 1'b1;
    drv_cyc = cyc;
  endtask

  // transmitter model: data symbol, then filler after six zeros
  task automatic tx(input logic b);
    line(b);
    dat_cyc = drv_cyc;
    if (b) zr = 0;
    else begin
      zr++;
      if (zr == 6) begin
        line(1'b1);
        zr = 0;
      end
    end
  endtask

  task automatic push(input logic [31:0] e);
    exp_q.push_back(e);
    due_q.push_back(dat_cyc + 2);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_valid = 1'b0;
    end
  endtask

  task automatic expect_quiet(input string tag, input int n);
    int e0;
    e0 = ev_cnt;
    settle(n);
    check(tag, (ev_cnt == e0) && (exp_q.size() == 0), ev_cnt - e0, 0);
  endtask

  function automatic logic [15:0] pat(input int seed, input int k);
    if (seed == 0) return 16'h0000;
    if (seed == 1) return (k % 2 == 0) ? 16'hFFFF : 16'h7007;
    return 16'(seed * (k + 3) * 40503 + k * 7919);
  endfunction

  task automatic send_head(input logic [3:0] ty, input logic [1:0] pad, input logic [9:0] ln);
    logic [15:0] h;
    for (int i = 0; i < 3; i++) tx(1'b1);
    h = {ty, pad, ln};
    for (int i = 15; i >= 0; i--) tx(h[i]);
    push({2'd1, 1'b0, 13'd0, ty, 2'b00, ln});
  endtask

  task automatic send_frame(input logic [3:0] ty, input logic [1:0] pad, input logic [9:0] ln, input int seed);
    logic [15:0] w;
    send_head(ty, pad, ln);
    for (int k = 0; k < int'(ln); k++) begin
      w = pat(seed, k);
      for (int i = 15; i >= 0; i--) tx(w[i]);
      push({2'd2, (k == int'(ln) - 1), 13'd0, w});
    end
  endtask

  // raw zeros up to the seventh in a row
  task automatic inject_err();
    for (int i = zr; i < 7; i++) line(1'b0);
    dat_cyc = drv_cyc;
    zr = 0;
    push({2'd3, 30'd0});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 outputs low in reset", {hdr_valid, word_valid, word_last, coding_err} == 4'b0,
          {hdr_valid, word_valid, word_last, coding_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 outputs low after reset", {hdr_valid, word_valid, coding_err} == 3'b0,
          {hdr_valid, word_valid, coding_err}, 0);

    // R3: idle zeros and broken start patterns
    for (int i = 0; i < 40; i++) tx(1'b0);
    tx(1'b1); tx(1'b1); tx(1'b0);
    for (int i = 0; i < 10; i++) tx(1'b0);
    tx(1'b1); tx(1'b0);
    expect_quiet("R3 partial start ignored", 5);

    // R10 stuffed idle, R4 R5 R6 basic frame with pad bits set
    for (int i = 0; i < 20; i++) tx(1'b0);
    send_frame(4'hA, 2'b01, 10'd3, 11);
    settle(4);

    // R6: ones-heavy payload does not restart a frame
    send_frame(4'h6, 2'b10, 10'd4, 1);
    settle(4);

    // R7: zero length, next frame right after
    send_frame(4'h3, 2'b00, 10'd0, 5);
    send_frame(4'hF, 2'b11, 10'd2, 1);
    settle(4);
    check("R7 zero-length frame done", exp_q.size() == 0, exp_q.size(), 0);

    // R10 R1: longest frame, header with filler, zero payload
    for (int i = 0; i < 9; i++) tx(1'b0);
    send_frame(4'h0, 2'b00, 10'h3FF, 0);
    settle(4);

    // R2: error inside a frame drops it
    for (int i = 0; i < 8; i++) tx(1'b0);
    send_head(4'h9, 2'b00, 10'd5);
    tx(1'b1); tx(1'b1);
    inject_err();
    settle(4);
    for (int i = 0; i < 30; i++) tx(1'b0);
    expect_quiet("R2 partial frame discarded", 4);
    send_frame(4'h2, 2'b00, 10'd1, 7);
    settle(4);

    // R2: error while idle
    tx(1'b1);
    inject_err();
    settle(4);
    for (int i = 0; i < 5; i++) tx(1'b0);
    send_frame(4'h4, 2'b01, 10'd2, 9);
    settle(4);

    // R8: sweep of types and short lengths with idle strobe gaps
    gapmode = 1'b1;
    for (int ty = 0; ty < 16; ty++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int z = 0; z < (ty + ln) % 9; z++) tx(1'b0);
        send_frame(4'(ty), 2'(ty), 10'(ln), ty * 4 + ln + 2);
      end
    end
    gapmode = 1'b0;
    settle(6);

    // R9: reset in the middle of a header
    for (int i = 0; i < 3; i++) tx(1'b1);
    for (int i = 0; i < 8; i++) tx(1'b0);
    @(negedge clk);
    rst = 1'b1;
    line_valid = 1'b0;
    settle(2);
    check("R9 reset mid-frame quiet", {hdr_valid, word_valid, coding_err} == 3'b0,
          {hdr_valid, word_valid, coding_err}, 0);
    rst = 1'b0;
    zr = 0;
    for (int i = 0; i < 4; i++) tx(1'b0);
    send_frame(4'hC, 2'b00, 10'd2, 13);
    settle(8);

    check("R5 all expected results seen", exp_q.size() == 0, exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end
endmodule